// File: doc/BRIEF.md
# Serial Clock-Calendar Slave

This block is the slave side of a two-wire serial link to a clock-calendar. A host drives a serial clock and a data bit from a register of its own, and reads a returned data bit. Each frame is sixteen bit periods. The first eight carry a command byte into the slave. The last eight either carry a data byte in or carry a byte back out. The command byte selects the target: one byte of a 32-byte battery-backed RAM, the status register, the control register, or one of the packed-BCD time-of-day fields.

The slave keeps its own calendar in binary counters that advance once per second from a tick input. It converts a field to BCD only when that field is read. Each tick also sets a status bit and raises an interrupt flag. Writing the control register with its acknowledge bit set clears both the status bits and the flag.

A chip-enable input frames each transaction. While it is low, the slave returns to the start of a frame.

Top module: `cal_serial_slave`

## Requirements
- R1: Bits are taken only on a falling edge of `serClk`: `serClk` sampled high on one cycle and low on the next while `chipEn` is high. Changes of `serDataIn` while the clock holds steady high or steady low shift nothing.
- R2: Falling edges 1 to 8 shift the command in MSB-first. Edges 9 to 16 form the data phase. Further edges before `chipEn` drops are ignored.
- R3: A command in 0x00..0x1F reads the RAM byte at that index. After the 8th edge, `serDataOut` shows bit 7. After each data-phase edge it shows the next lower bit.
- R4: A command in 0x80..0x9F writes the eight data-phase bits, MSB first, to RAM index (command − 0x80). The write takes effect on the 16th edge.
- R5: Command 0x30 reads the status byte. Its reset value is 0x90. Every tick sets its bit 0x08.
- R6: Command 0xB1 writes the control byte and command 0x31 reads it back. The control byte resets to 0x00.
- R7: A control write whose data has bit 0x04 set clears status bits 0x18 and drops `clkIrq` on the following cycle, unless a tick lands in that cycle.
- R8: `clkIrq` resets low. It rises on the cycle after a tick and at no other time.
- R9: Time is read in two-digit packed BCD with these command codes:
  - 0x20 returns seconds.
  - 0x21 returns minutes.
  - 0x22 returns hours (0..23).
  - 0x23 returns the day of the month.
  - 0x24 returns the month (1..12).
  - 0x25 returns the year modulo 100.
  - 0x26..0x2F return 0x00.
- R10: The time after reset is 00:00:00, day 1, month 1, year 00. Each cycle with `secTick` high adds one second. Seconds and minutes roll over at 60 and hours at 24. Days roll over after 28, 30 or 31 according to the month. Month 12 rolls over to 1 and the year steps modulo 100.
- R11: Dropping `chipEn` aborts the frame without any write, and `serDataOut` is 0 from the next cycle.
- R12: The byte being read is captured at the 8th edge. Ticks during the data phase do not change the bits being shifted out.
- R13: Any other command writes nothing, and it reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipEn | input | 1 | Frames a transaction; low aborts and restarts the frame |
| serClk | input | 1 | Host serial clock, synchronous to `clk` |
| serDataIn | input | 1 | Host-to-slave data bit |
| secTick | input | 1 | One-second advance, one second per high cycle |
| serDataOut | output | 1 | Slave-to-host data bit |
| clkIrq | output | 1 | Clock interrupt flag |

## Verification
The hardest situation to reach is the calendar rolling past hour and day boundaries, because that takes tens of thousands of seconds. The bench holds `secTick` high for long stretches, which adds one second per cycle, then reads every field against a count-based model. A second hard case is a tick that arrives partway through a read. The stimulus raises it between data-phase edges and expects the value captured before the tick. Random RAM traffic toggles the data line while the clock is steady, so any sampling outside a true falling edge would corrupt the stored bytes.

// File: rtl/cal_serial_pkg.sv
package cal_serial_pkg;
  localparam int RAM_WORDS  = 32;
  localparam int RAM_AW     = $clog2(RAM_WORDS);
  localparam int CMD_BITS   = 8;
  localparam int FRAME_BITS = 2 * CMD_BITS;
  localparam int PH_W       = $clog2(FRAME_BITS) + 1;

  localparam logic [7:0] CMD_STATUS_RD = 8'h30;
  localparam logic [7:0] CMD_CTRL_RD   = 8'h31;
  localparam logic [7:0] CMD_CTRL_WR   = 8'hB1;
  localparam logic [7:0] CMD_RAM_WR    = 8'h80;
  localparam logic [7:0] CMD_TIME      = 8'h20;

  localparam logic [7:0] STATUS_INIT  = 8'h90;
  localparam logic [7:0] STATUS_ACKED = 8'h18;
  localparam logic [7:0] STATUS_TICK  = 8'h08;
  localparam int         CTRL_ACK_BIT = 2;

  typedef struct packed {
    logic       cmdLoad;
    logic       shiftOut;
    logic       commit;
    logic       abort;
    logic [7:0] cmdByte;
    logic [7:0] dataByte;
  } strobe_t;

  function automatic logic [7:0] toBcd(input logic [6:0] v);
    toBcd = {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction
endpackage

// File: rtl/cal_time_keeper.sv
module cal_time_keeper (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  output logic [5:0] sec,
  output logic [5:0] min,
  output logic [4:0] hour,
  output logic [4:0] day,
  output logic [3:0] month,
  output logic [6:0] year
);
  function automatic logic [4:0] lastDay(input logic [3:0] m);
    case (m)
      4'd2:                      lastDay = 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   lastDay = 5'd30;
      default:                   lastDay = 5'd31;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sec <= '0; min <= '0; hour <= '0;
      day <= 5'd1; month <= 4'd1; year <= '0;
    end else if (tick) begin
      if (sec != 6'd59) sec <= sec + 6'd1;
      else begin
        sec <= '0;
        if (min != 6'd59) min <= min + 6'd1;
        else begin
          min <= '0;
          if (hour != 5'd23) hour <= hour + 5'd1;
          else begin
            hour <= '0;
            if (day != lastDay(month)) day <= day + 5'd1;
            else begin
              day <= 5'd1;
              if (month != 4'd12) month <= month + 4'd1;
              else begin
                month <= 4'd1;
                year  <= (year == 7'd99) ? 7'd0 : year + 7'd1;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/cal_serial_ctrl.sv
module cal_serial_ctrl
  import cal_serial_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    chipEn,
  input  logic    serClk,
  input  logic    serDataIn,
  output strobe_t strb
);
  localparam logic [PH_W-1:0] LAST_CMD = PH_W'(CMD_BITS - 1);
  localparam logic [PH_W-1:0] LAST_BIT = PH_W'(FRAME_BITS - 1);
  localparam logic [PH_W-1:0] DONE     = PH_W'(FRAME_BITS);

  logic            prevClk;
  logic [PH_W-1:0] phase;
  logic [7:0]      cmdReg;
  logic [7:0]      valReg;
  logic            fallEdge;
  logic            inCmd;

  assign fallEdge = chipEn && prevClk && !serClk && (phase < DONE);
  assign inCmd    = (phase <= LAST_CMD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClk <= 1'b0;
      phase   <= '0;
      cmdReg  <= '0;
      valReg  <= '0;
    end else begin
      prevClk <= serClk;
      if (!chipEn) begin
        phase  <= '0;
        cmdReg <= '0;
        valReg <= '0;
      end else if (fallEdge) begin
        phase <= phase + 1'b1;
        if (inCmd) cmdReg <= {cmdReg[6:0], serDataIn};
        else       valReg <= {valReg[6:0], serDataIn};
      end
    end
  end

  always_comb begin
    strb.abort    = !chipEn;
    strb.cmdLoad  = fallEdge && (phase == LAST_CMD);
    strb.shiftOut = fallEdge && !inCmd;
    strb.commit   = fallEdge && (phase == LAST_BIT);
    strb.cmdByte  = strb.cmdLoad ? {cmdReg[6:0], serDataIn} : cmdReg;
    strb.dataByte = {valReg[6:0], serDataIn};
  end
endmodule

// File: rtl/cal_serial_datapath.sv
module cal_serial_datapath
  import cal_serial_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  input  logic    secTick,
  output logic    serDataOut,
  output logic    clkIrq
);
  logic [7:0] ram [RAM_WORDS];
  logic [7:0] statusReg, ctrlReg, outShift, outNext;
  logic       readOn;
  logic [5:0] sec, min;
  logic [4:0] hour, day;
  logic [3:0] month;
  logic [6:0] year;

  cal_time_keeper u_time (
    .clk(clk), .rstN(rstN), .tick(secTick),
    .sec(sec), .min(min), .hour(hour), .day(day), .month(month), .year(year)
  );

  always_comb begin
    outNext = 8'h00;
    if (strb.cmdByte[7:RAM_AW] == '0)
      outNext = ram[strb.cmdByte[RAM_AW-1:0]];
    else if (strb.cmdByte == CMD_STATUS_RD)
      outNext = statusReg;
    else if (strb.cmdByte == CMD_CTRL_RD)
      outNext = ctrlReg;
    else if (strb.cmdByte[7:4] == CMD_TIME[7:4]) begin
      case (strb.cmdByte[3:0])
        4'd0:    outNext = toBcd(7'(sec));
        4'd1:    outNext = toBcd(7'(min));
        4'd2:    outNext = toBcd(7'(hour));
        4'd3:    outNext = toBcd(7'(day));
        4'd4:    outNext = toBcd(7'(month));
        4'd5:    outNext = toBcd(year);
        default: outNext = 8'h00;
      endcase
    end
  end

  assign serDataOut = readOn & outShift[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      readOn   <= 1'b0;
    end else if (strb.abort) begin
      outShift <= '0;
      readOn   <= 1'b0;
    end else if (strb.cmdLoad) begin
      outShift <= outNext;
      readOn   <= 1'b1;
    end else if (strb.shiftOut) begin
      outShift <= {outShift[6:0], 1'b0};
      if (strb.commit) readOn <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < RAM_WORDS; i++) ram[i] <= '0;
      statusReg <= STATUS_INIT;
      ctrlReg   <= '0;
      clkIrq    <= 1'b0;
    end else begin
      if (strb.commit) begin
        if (strb.cmdByte[7:RAM_AW] == CMD_RAM_WR[7:RAM_AW])
          ram[strb.cmdByte[RAM_AW-1:0]] <= strb.dataByte;
        if (strb.cmdByte == CMD_CTRL_WR) begin
          ctrlReg <= strb.dataByte;
          if (strb.dataByte[CTRL_ACK_BIT]) begin
            statusReg <= (statusReg & ~STATUS_ACKED) | (secTick ? STATUS_TICK : 8'h00);
            clkIrq    <= secTick;
          end
        end
      end
      if (secTick) begin
        statusReg[3] <= 1'b1;
        clkIrq       <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cal_serial_slave.sv
module cal_serial_slave
  import cal_serial_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic chipEn,
  input  logic serClk,
  input  logic serDataIn,
  input  logic secTick,
  output logic serDataOut,
  output logic clkIrq
);
  strobe_t strb;

  cal_serial_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .chipEn(chipEn),
    .serClk(serClk), .serDataIn(serDataIn), .strb(strb)
  );

  cal_serial_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .secTick(secTick),
    .serDataOut(serDataOut), .clkIrq(clkIrq)
  );
endmodule

// File: rtl/cal_serial_checker.sv
module cal_serial_checker (
  input logic clk,
  input logic rstN,
  input logic chipEn,
  input logic serClk,
  input logic secTick,
  input logic serDataOut,
  input logic clkIrq
);
  logic lastClk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastClk <= 1'b0;
    else       lastClk <= serClk;
  end

  p_quiet_after_disable_r11: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn |=> !serDataOut);

  p_hold_without_edge_r12: assert property (@(posedge clk) disable iff (!rstN)
    (chipEn && !(lastClk && !serClk)) |=> $stable(serDataOut));

  p_irq_after_tick_r8: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> clkIrq);

  p_irq_rise_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkIrq) |-> $past(secTick));

  p_irq_clear_on_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkIrq) |-> $past(chipEn && lastClk && !serClk));
endmodule

bind cal_serial_slave cal_serial_checker u_chk (
  .clk(clk), .rstN(rstN), .chipEn(chipEn), .serClk(serClk),
  .secTick(secTick), .serDataOut(serDataOut), .clkIrq(clkIrq)
);

// File: tb/cal_serial_slave_test.sv
module cal_serial_slave_test;
  logic clk = 1'b0, rstN = 1'b0, chipEn = 1'b0, serClk = 1'b0;
  logic serDataIn = 1'b0, secTick = 1'b0;
  logic serDataOut, clkIrq;
  int   nChecks = 0, nFails = 0;
  int   secs = 0;
  logic [7:0] ramModel [32];
  logic [7:0] rd;

  always #5 clk = ~clk;

  cal_serial_slave uut (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .serClk(serClk),
    .serDataIn(serDataIn), .secTick(secTick),
    .serDataOut(serDataOut), .clkIrq(clkIrq)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] timeField(input int code, input int n);
    case (code)
      0: return bcd(n % 60);
      1: return bcd((n / 60) % 60);
      2: return bcd((n / 3600) % 24);
      3: return bcd(1 + n / 86400);
      4: return 8'h01;
      5: return 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One framed transaction; nBits edges, optional tick pulse at bit tickAt.
  task automatic xfer(input logic [7:0] cmd, input logic [7:0] wdat, input int nBits,
                      input int tickAt, output logic [7:0] rdat);
    logic [15:0] frame;
    frame = {cmd, wdat};
    rdat = 8'h00;
    @(negedge clk); chipEn = 1'b1;
    waitN(1);
    for (int b = 0; b < nBits; b++) begin
      serDataIn = (b < 16) ? frame[15-b] : 1'($urandom);
      serClk = 1'b1;
      waitN(1);
      if (b == tickAt) begin secTick = 1'b1; waitN(1); secTick = 1'b0; end
      if (b >= 8 && b < 16) rdat = {rdat[6:0], serDataOut};
      waitN(1);
      serClk = 1'b0;
      waitN(1);
      serDataIn = ~serDataIn;   // toggle while clock held low (R1)
      waitN(1);
    end
    chipEn = 1'b0;
    waitN(2);
  endtask

  task automatic ticks(input int n);
    @(negedge clk); secTick = 1'b1;
    waitN(n);
    secTick = 1'b0;
    secs += n;
  endtask

  initial begin
    #1900000;
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 32; i++) ramModel[i] = 8'h00;
    waitN(3);
    rstN = 1'b1;
    waitN(2);
    check("R8 reset irq", {7'b0, clkIrq}, 8'h00);
    check("R11 reset out", {7'b0, serDataOut}, 8'h00);

    xfer(8'h30, 8'h00, 16, -1, rd); check("R5 status reset", rd, 8'h90);
    xfer(8'h31, 8'h00, 16, -1, rd); check("R6 control reset", rd, 8'h00);
    xfer(8'h24, 8'h00, 16, -1, rd); check("R10 month after reset", rd, 8'h01);
    xfer(8'h23, 8'h00, 16, -1, rd); check("R10 day after reset", rd, 8'h01);

    // Random RAM traffic (R1 R3 R4)
    for (int k = 0; k < 10; k++) begin
      int idx; logic [7:0] d;
      idx = $urandom_range(0, 31);
      d = 8'($urandom);
      xfer(8'h80 + 8'(idx), d, 16, -1, rd);
      ramModel[idx] = d;
      idx = $urandom_range(0, 31);
      xfer(8'(idx), 8'h00, 16, -1, rd);
      check("R3 R4 RAM readback", rd, ramModel[idx]);
    end
    xfer(8'h9F, 8'hA5, 16, -1, rd); ramModel[31] = 8'hA5;
    xfer(8'h1F, 8'h00, 16, -1, rd); check("R4 top RAM index", rd, 8'hA5);
    xfer(8'h80, 8'h3C, 16, -1, rd); ramModel[0] = 8'h3C;
    xfer(8'h00, 8'h00, 16, -1, rd); check("R3 RAM index 0", rd, 8'h3C);

    // Abort after 12 edges: no write (R11)
    xfer(8'h85, 8'hFF, 12, -1, rd);
    check("R11 out after abort", {7'b0, serDataOut}, 8'h00);
    xfer(8'h05, 8'h00, 16, -1, rd); check("R11 aborted write", rd, ramModel[5]);

    // Extra edges after 16 ignored (R2)
    xfer(8'h86, 8'h5A, 20, -1, rd); ramModel[6] = 8'h5A;
    xfer(8'h06, 8'h00, 16, -1, rd); check("R2 extra edges ignored", rd, 8'h5A);

    // Unlisted codes (R13, R9)
    xfer(8'h50, 8'h00, 16, -1, rd); check("R13 unlisted reads zero", rd, 8'h00);
    xfer(8'hC3, 8'h77, 16, -1, rd);
    xfer(8'h03, 8'h00, 16, -1, rd); check("R13 unlisted writes nothing", rd, ramModel[3]);
    xfer(8'h2A, 8'h00, 16, -1, rd); check("R9 unused time code", rd, 8'h00);

    // Tick, irq and status (R8 R5 R7 R6)
    ticks(1);
    waitN(1);
    check("R8 irq after tick", {7'b0, clkIrq}, 8'h01);
    xfer(8'h30, 8'h00, 16, -1, rd); check("R5 status tick bit", rd, 8'h98);
    xfer(8'hB1, 8'h00, 16, -1, rd);
    check("R7 no ack keeps irq", {7'b0, clkIrq}, 8'h01);
    xfer(8'hB1, 8'h04, 16, -1, rd);
    check("R7 ack clears irq", {7'b0, clkIrq}, 8'h00);
    xfer(8'h30, 8'h00, 16, -1, rd); check("R7 ack clears status", rd, 8'h80);
    xfer(8'h31, 8'h00, 16, -1, rd); check("R6 control readback", rd, 8'h04);

    // Minute rollover (R10 R9)
    ticks(59);
    xfer(8'h20, 8'h00, 16, -1, rd); check("R10 seconds wrap", rd, timeField(0, secs));
    xfer(8'h21, 8'h00, 16, -1, rd); check("R10 minute step", rd, timeField(1, secs));

    // Tick during data phase: captured value kept (R12)
    ticks(4);
    xfer(8'h20, 8'h00, 16, 10, rd);
    check("R12 latched during tick", rd, timeField(0, secs));
    secs += 1;
    xfer(8'h20, 8'h00, 16, -1, rd); check("R12 next read updated", rd, timeField(0, secs));

    // Long run past hour and day boundaries (R10 R9)
    ticks(86400 + 5 * 3600 + 7 * 60 + 9 - secs);
    for (int c = 0; c < 8; c++) begin
      xfer(8'h20 + 8'(c), 8'h00, 16, -1, rd);
      check("R9 R10 time field", rd, timeField(c, secs));
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule